// File: doc/BRIEF.md
# Write Beat Count Checker

A passive monitor for the write side of an AXI interface. It observes the address, data and response channels and raises one-cycle error flags when a burst carries the wrong number of data beats or a misplaced last marker. It also flags a write response that starts before its burst has finished on both the address and data channels, and a set strobe bit outside the byte lanes allowed for the beat. It drives nothing back onto the bus.

Data may arrive before its address. Address entries and finished data-burst beat counts are held in two bounded queues and paired strictly in order. A response becomes due once both halves of a pair exist. A queue that is asked to hold more than `MAX_BURSTS` outstanding items raises an overflow flag. A response handshake with nothing due raises an underflow flag. The monitor also checks that write-valid is low in the first cycle after reset, and that the write payload holds steady while a beat is stalled.

Top module: `axi_wbeat_chk`

## Requirements
- R1: While reset is low, and in the first cycle after it with idle inputs, every flag output is 0. Each flag is a one-cycle pulse, high in the cycle after the clock edge that sampled the offending input.
- R2: `len_last_err_o` pulses when a data beat with last set is accepted and the beat count of its burst differs from length+1 of its already known address.
- R3: `len_nolast_err_o` pulses when a data beat without last is accepted and the count including that beat has reached length+1 of its known address.
- R4: `len_late_err_o` pulses when an address is accepted whose burst had already completed without a known address, and that burst's beat count differs from the new length+1.
- R5: Addresses and data bursts pair in arrival order, including data that leads its address and an address accepted in the same cycle as the burst's first or last beat. Matching counts raise no flag.
- R6: `bresp_early_err_o` pulses when response-valid starts a new response (it rises, or stays high after a response handshake) while no response is due. A response is due once both the address and the last beat of a burst have been accepted in earlier cycles.
- R7: `resp_udf_o` pulses when a response handshake occurs while no response is due.
- R8: `ovf_o` pulses when an address or a finished data burst must be queued while `MAX_BURSTS` items of that kind already wait, or when a response becomes due while `MAX_BURSTS` responses are due.
- R9: For increment bursts (burst code 1), `strb_err_o` pulses when a strobe bit is set outside the lanes of the beat. Beat 0 covers the start address up to the end of its size-aligned unit. Beat n>0 covers the size-aligned start plus n times the size, for one size unit, taken modulo the bus width in bytes.
- R10: For fixed bursts (burst code 0), every beat is held to the lanes of beat 0.
- R11: For wrapping bursts (burst code 2), the beat address wraps within a window of (length+1) times the size, aligned to that window.
- R12: `wvalid_rst_err_o` pulses if write-valid is high in the first cycle after reset.
- R13: `wstable_err_o` pulses when a beat stalled (valid high, ready low) in one cycle is still valid in the next but its data, strobe, last or user field changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_addr_i | input | ADDR_W | Write start address |
| aw_len_i | input | 8 | Beats minus one |
| aw_size_i | input | 3 | log2 of bytes per beat |
| aw_burst_i | input | 2 | Burst code: 0 fixed, 1 increment, 2 wrap |
| w_valid_i | input | 1 | Write data valid |
| w_ready_i | input | 1 | Write data ready |
| w_data_i | input | DATA_W | Write data |
| w_strb_i | input | DATA_W/8 | Byte strobes |
| w_last_i | input | 1 | Last beat of burst |
| w_user_i | input | USER_W | Write user field |
| b_valid_i | input | 1 | Response valid |
| b_ready_i | input | 1 | Response ready |
| len_last_err_o | output | 1 | Count wrong at last beat |
| len_nolast_err_o | output | 1 | Last marker missing on final beat |
| len_late_err_o | output | 1 | Late address does not match counted burst |
| bresp_early_err_o | output | 1 | Response started before it was due |
| resp_udf_o | output | 1 | Response taken with nothing due |
| ovf_o | output | 1 | Outstanding limit exceeded |
| strb_err_o | output | 1 | Strobe outside allowed lanes |
| wvalid_rst_err_o | output | 1 | Write-valid high right after reset |
| wstable_err_o | output | 1 | Stalled payload changed |

## Verification
Every flag is registered once, so it is due exactly one cycle after the edge that sampled the stimulus. The bench changes inputs 1 ns after a rising edge and reads the flags 1 ns after the following rising edge, so each check observes the cycle its stimulus caused. Response-start detection uses state from the previous cycle. Its checks therefore drop response-valid for a cycle between directed responses, so that each response starts on its own. Strobe expectations come from a bench function that derives the beat's lane window by integer division rather than masking.

// File: rtl/axi_wbeat_pkg.sv
package axi_wbeat_pkg;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
  localparam int CNT_W  = LEN_W + 1;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/wbc_fifo.sv
module wbc_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/wbc_lane_mask.sv
module wbc_lane_mask
  import axi_wbeat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NB     = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        burst_i,
  input  logic [CNT_W-1:0]  beat_i,
  output logic [NB-1:0]     mask_o
);
  logic [ADDR_W-1:0] sz, al, step, wwin, baddr, lo, hi;

  always_comb begin
    sz    = ADDR_W'(1) << size_i;
    al    = addr_i & ~(sz - ADDR_W'(1));
    step  = ADDR_W'(beat_i) << size_i;
    wwin  = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
    case (burst_e'(burst_i))
      BURST_INCR: baddr = (beat_i == '0) ? addr_i : al + step;
      BURST_WRAP: baddr = (al & ~wwin) | ((al + step) & wwin);
      default:    baddr = addr_i;
    endcase
    lo = baddr & ADDR_W'(NB - 1);
    hi = ((baddr & ~(sz - ADDR_W'(1))) & ADDR_W'(NB - 1)) + sz - ADDR_W'(1);
    for (int i = 0; i < NB; i++) begin
      mask_o[i] = (ADDR_W'(i) >= lo) && (ADDR_W'(i) <= hi);
    end
  end
endmodule

// File: rtl/wbc_wchan_rules.sv
module wbc_wchan_rules #(
  parameter int DATA_W = 64,
  parameter int USER_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                w_valid_i,
  input  logic                w_ready_i,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  input  logic [USER_W-1:0]   w_user_i,
  output logic                rst_err_o,
  output logic                stable_err_o
);
  localparam int PL_W = DATA_W + DATA_W / 8 + 1 + USER_W;

  logic            first_q, stall_q;
  logic [PL_W-1:0] pl, pl_q;

  assign pl = {w_data_i, w_strb_i, w_last_i, w_user_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q      <= 1'b1;
      stall_q      <= 1'b0;
      pl_q         <= '0;
      rst_err_o    <= 1'b0;
      stable_err_o <= 1'b0;
    end else begin
      first_q      <= 1'b0;
      stall_q      <= w_valid_i & ~w_ready_i;
      pl_q         <= pl;
      rst_err_o    <= first_q & w_valid_i;
      stable_err_o <= stall_q & w_valid_i & (pl != pl_q);
    end
  end
endmodule

// File: rtl/axi_wbeat_chk.sv
module axi_wbeat_chk
  import axi_wbeat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int USER_W     = 4,
  parameter int MAX_BURSTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aw_valid_i,
  input  logic                aw_ready_i,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [LEN_W-1:0]    aw_len_i,
  input  logic [SIZE_W-1:0]   aw_size_i,
  input  logic [1:0]          aw_burst_i,
  input  logic                w_valid_i,
  input  logic                w_ready_i,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  input  logic [USER_W-1:0]   w_user_i,
  input  logic                b_valid_i,
  input  logic                b_ready_i,
  output logic                len_last_err_o,
  output logic                len_nolast_err_o,
  output logic                len_late_err_o,
  output logic                bresp_early_err_o,
  output logic                resp_udf_o,
  output logic                ovf_o,
  output logic                strb_err_o,
  output logic                wvalid_rst_err_o,
  output logic                wstable_err_o
);
  localparam int NB    = DATA_W / 8;
  localparam int DUE_W = $clog2(MAX_BURSTS + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [SIZE_W-1:0] size;
    logic [1:0]        burst;
  } aw_ent_t;
  localparam int EW = $bits(aw_ent_t);

  logic aw_hs, w_hs, b_hs;
  assign aw_hs = aw_valid_i & aw_ready_i;
  assign w_hs  = w_valid_i & w_ready_i;
  assign b_hs  = b_valid_i & b_ready_i;

  // address queue and data-count queue; at most one is non-empty
  aw_ent_t             aw_in, awq_head;
  logic                awq_push, awq_pop, awq_empty, awq_full;
  logic [CNT_W-1:0]    wcq_head;
  logic                wcq_push, wcq_pop, wcq_empty, wcq_full;
  logic [CNT_W-1:0]    beat_q, cnt_next;

  assign aw_in = '{addr: aw_addr_i, len: aw_len_i, size: aw_size_i, burst: aw_burst_i};

  wbc_fifo #(.DEPTH(MAX_BURSTS), .WIDTH(EW)) u_awq (
    .clk_i, .rst_ni,
    .push_i(awq_push), .din_i(aw_in), .pop_i(awq_pop),
    .head_o(awq_head), .empty_o(awq_empty), .full_o(awq_full)
  );

  wbc_fifo #(.DEPTH(MAX_BURSTS), .WIDTH(CNT_W)) u_wcq (
    .clk_i, .rst_ni,
    .push_i(wcq_push), .din_i(cnt_next), .pop_i(wcq_pop),
    .head_o(wcq_head), .empty_o(wcq_empty), .full_o(wcq_full)
  );

  // address of the burst currently on the data channel
  logic    cur_from_q, cur_from_in, cur_known, burst_done;
  aw_ent_t cur;
  logic [CNT_W-1:0] cur_exp, late_exp;

  assign cur_from_q  = ~awq_empty;
  assign cur_from_in = awq_empty & wcq_empty & aw_hs;
  assign cur_known   = cur_from_q | cur_from_in;
  assign cur         = cur_from_q ? awq_head : aw_in;
  assign cur_exp     = CNT_W'(cur.len) + CNT_W'(1);
  assign late_exp    = CNT_W'(aw_len_i) + CNT_W'(1);
  assign cnt_next    = (beat_q == '1) ? beat_q : beat_q + CNT_W'(1);
  assign burst_done  = w_hs & w_last_i;

  assign awq_push = aw_hs & wcq_empty & ~(cur_from_in & burst_done);
  assign awq_pop  = burst_done & cur_from_q;
  assign wcq_push = burst_done & ~cur_known;
  assign wcq_pop  = aw_hs & ~wcq_empty;

  logic [NB-1:0] lane_ok;
  wbc_lane_mask #(.ADDR_W(ADDR_W), .NB(NB)) u_lane (
    .addr_i(cur.addr), .len_i(cur.len), .size_i(cur.size),
    .burst_i(cur.burst), .beat_i(beat_q), .mask_o(lane_ok)
  );

  // responses that may be issued
  logic [DUE_W-1:0] due_q;
  logic due_inc, due_dec, due_full, bv_q, bhs_q, b_start;

  assign due_inc  = (burst_done & cur_known) | wcq_pop;
  assign due_dec  = b_hs & (due_q != '0);
  assign due_full = (due_q == DUE_W'(MAX_BURSTS));
  assign b_start  = b_valid_i & (~bv_q | bhs_q);

  logic last_err_d, nolast_err_d, late_err_d, strb_err_d, ovf_d;

  always_comb begin
    last_err_d   = burst_done & cur_known & (cnt_next != cur_exp);
    nolast_err_d = w_hs & ~w_last_i & cur_known & (cnt_next >= cur_exp);
    late_err_d   = wcq_pop & (wcq_head != late_exp);
    strb_err_d   = w_hs & cur_known & (|(w_strb_i & ~lane_ok));
    ovf_d        = (awq_push & awq_full) | (wcq_push & wcq_full) |
                   (due_inc & due_full & ~due_dec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q            <= '0;
      due_q             <= '0;
      bv_q              <= 1'b0;
      bhs_q             <= 1'b0;
      len_last_err_o    <= 1'b0;
      len_nolast_err_o  <= 1'b0;
      len_late_err_o    <= 1'b0;
      bresp_early_err_o <= 1'b0;
      resp_udf_o        <= 1'b0;
      ovf_o             <= 1'b0;
      strb_err_o        <= 1'b0;
    end else begin
      if (w_hs) beat_q <= w_last_i ? '0 : cnt_next;
      if (due_inc && !due_full && !due_dec)  due_q <= due_q + DUE_W'(1);
      else if (due_dec && !due_inc)          due_q <= due_q - DUE_W'(1);
      bv_q              <= b_valid_i;
      bhs_q             <= b_hs;
      len_last_err_o    <= last_err_d;
      len_nolast_err_o  <= nolast_err_d;
      len_late_err_o    <= late_err_d;
      bresp_early_err_o <= b_start & (due_q == '0);
      resp_udf_o        <= b_hs & (due_q == '0);
      ovf_o             <= ovf_d;
      strb_err_o        <= strb_err_d;
    end
  end

  wbc_wchan_rules #(.DATA_W(DATA_W), .USER_W(USER_W)) u_wrules (
    .clk_i, .rst_ni,
    .w_valid_i, .w_ready_i, .w_data_i, .w_strb_i, .w_last_i, .w_user_i,
    .rst_err_o(wvalid_rst_err_o), .stable_err_o(wstable_err_o)
  );
endmodule

// File: rtl/axi_wbeat_chk_sva.sv
module axi_wbeat_chk_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic aw_valid_i,
  input logic aw_ready_i,
  input logic w_valid_i,
  input logic w_ready_i,
  input logic w_last_i,
  input logic b_valid_i,
  input logic b_ready_i,
  input logic len_last_err_o,
  input logic len_nolast_err_o,
  input logic len_late_err_o,
  input logic bresp_early_err_o,
  input logic resp_udf_o,
  input logic strb_err_o,
  input logic wstable_err_o
);
  // R2
  last_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_last_err_o |-> $past(w_valid_i & w_ready_i & w_last_i));
  // R3
  nolast_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_nolast_err_o |-> $past(w_valid_i & w_ready_i & ~w_last_i));
  // R4
  late_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_late_err_o |-> $past(aw_valid_i & aw_ready_i));
  // R6
  early_b_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bresp_early_err_o |-> $past(b_valid_i));
  // R7
  udf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_udf_o |-> $past(b_valid_i & b_ready_i));
  // R9
  strb_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_err_o |-> $past(w_valid_i & w_ready_i));
  // R13
  wstable_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstable_err_o |-> $past(w_valid_i));
endmodule

bind axi_wbeat_chk axi_wbeat_chk_sva u_sva (.*);

// File: tb/axi_wbeat_chk_bench.sv
module axi_wbeat_chk_bench;
  localparam int NB = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0;
  logic [31:0] aw_addr = '0;
  logic [7:0]  aw_len = '0;
  logic [2:0]  aw_size = '0;
  logic [1:0]  aw_burst = '0;
  logic [63:0] w_data = '0;
  logic [7:0]  w_strb = '0;
  logic [3:0]  w_user = '0;
  logic len_last_err, len_nolast_err, len_late_err, bresp_early_err;
  logic resp_udf, ovf, strb_err, wvalid_rst_err, wstable_err;

  int checks = 0;
  int errs = 0;

  always #5 clk_i = ~clk_i;

  axi_wbeat_chk u_axi_wbeat_chk (
    .clk_i, .rst_ni,
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_addr_i(aw_addr),
    .aw_len_i(aw_len), .aw_size_i(aw_size), .aw_burst_i(aw_burst),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_data_i(w_data),
    .w_strb_i(w_strb), .w_last_i(w_last), .w_user_i(w_user),
    .b_valid_i(b_valid), .b_ready_i(b_ready),
    .len_last_err_o(len_last_err), .len_nolast_err_o(len_nolast_err),
    .len_late_err_o(len_late_err), .bresp_early_err_o(bresp_early_err),
    .resp_udf_o(resp_udf), .ovf_o(ovf), .strb_err_o(strb_err),
    .wvalid_rst_err_o(wvalid_rst_err), .wstable_err_o(wstable_err)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: run hung act=running exp=finished");
    summary();
    $finish;
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] flags();
    return {len_last_err, len_nolast_err, len_late_err, bresp_early_err,
            resp_udf, ovf, strb_err, wvalid_rst_err, wstable_err};
  endfunction

  task automatic chk_quiet(string tag);
    checks++;
    if (flags() !== 9'd0) begin
      errs++;
      $display("FAIL %s flags act=%b exp=%b", tag, flags(), 9'd0);
    end
  endtask

  // allowed lanes derived by division (R9, R10, R11)
  function automatic logic [7:0] exp_mask(int addr, int len, int size, int burst, int beat);
    int sz, al, b, lo, hi, wb, wbase;
    logic [7:0] m;
    sz = 1 << size;
    al = (addr / sz) * sz;
    if (burst == 1)      b = (beat == 0) ? addr : al + beat * sz;
    else if (burst == 2) begin
      wb = (len + 1) * sz;
      wbase = (al / wb) * wb;
      b = wbase + ((al - wbase + beat * sz) % wb);
    end else b = addr;
    lo = b % NB;
    hi = ((b / sz) * sz) % NB + sz - 1;
    for (int i = 0; i < NB; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  task automatic aw(int addr, int len, int size, int burst, logic exp_late, string tag);
    aw_valid = 1; aw_ready = 1;
    aw_addr = 32'(addr); aw_len = 8'(len); aw_size = 3'(size); aw_burst = 2'(burst);
    tick();
    aw_valid = 0;
    chk({tag, " R4 late"}, len_late_err, exp_late);
  endtask

  task automatic wb(logic [7:0] strb, logic last, logic e_last, logic e_nolast,
                    logic e_strb, string tag);
    w_valid = 1; w_ready = 1; w_strb = strb; w_last = last;
    w_data = {$urandom, $urandom}; w_user = 4'($urandom);
    tick();
    w_valid = 0; w_last = 0;
    chk({tag, " R2 last"}, len_last_err, e_last);
    chk({tag, " R3 nolast"}, len_nolast_err, e_nolast);
    chk({tag, " R9 strb"}, strb_err, e_strb);
  endtask

  task automatic bresp(logic e_early, logic e_udf, string tag);
    b_valid = 1; b_ready = 1;
    tick();
    b_valid = 0; b_ready = 0;
    chk({tag, " R6 early"}, bresp_early_err, e_early);
    chk({tag, " R7 udf"}, resp_udf, e_udf);
    tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 / R12: reset, with write-valid high across release
    w_valid = 1; w_ready = 0;
    repeat (2) @(posedge clk_i);
    #1;
    chk_quiet("R1 in reset");
    rst_ni = 1;
    tick();
    chk("R12 wvalid after reset", wvalid_rst_err, 1'b1);
    w_valid = 0;
    tick();
    chk("R12 pulse clears", wvalid_rst_err, 1'b0);
    chk("R13 valid dropped no err", wstable_err, 1'b0);
    tick();
    chk_quiet("R1 idle");

    // R5 normal burst
    aw(32'h100, 3, 3, 1, 0, "R5 norm");
    for (int i = 0; i < 4; i++) wb(8'hFF, i == 3, 0, 0, 0, "R5 norm");
    bresp(0, 0, "R5 norm");

    // R6/R7 response with nothing due
    bresp(1, 1, "R6 none due");

    // R2 early last
    aw(0, 3, 3, 1, 0, "R2 early");
    wb(8'hFF, 0, 0, 0, 0, "R2 early");
    wb(8'hFF, 1, 1, 0, 0, "R2 early");
    bresp(0, 0, "R2 early");

    // R3 missing last, then overlong last
    aw(0, 1, 3, 1, 0, "R3 miss");
    wb(8'hFF, 0, 0, 0, 0, "R3 miss");
    wb(8'hFF, 0, 0, 1, 0, "R3 miss");
    wb(8'hFF, 1, 1, 0, 0, "R3 miss");
    bresp(0, 0, "R3 miss");

    // R5/R6 data before address, matching
    for (int i = 0; i < 3; i++) wb(8'hFF, i == 2, 0, 0, 0, "R5 lead");
    b_valid = 1; b_ready = 0;
    tick();
    b_valid = 0;
    chk("R6 resp before address", bresp_early_err, 1'b1);
    tick();
    aw(32'h40, 2, 3, 1, 0, "R5 lead");
    bresp(0, 0, "R5 lead");

    // R4 data before address, mismatching
    wb(8'hFF, 0, 0, 0, 0, "R4 lead");
    wb(8'hFF, 1, 0, 0, 0, "R4 lead");
    aw(32'h80, 4, 3, 1, 1, "R4 mismatch");
    bresp(0, 0, "R4 mismatch");

    // R5 address in same cycle as single last beat
    aw_valid = 1; aw_ready = 1; aw_addr = 0; aw_len = 0; aw_size = 3; aw_burst = 1;
    w_valid = 1; w_ready = 1; w_strb = 8'hFF; w_last = 1;
    tick();
    aw_valid = 0; w_valid = 0; w_last = 0;
    chk_quiet("R5 same cycle last");
    bresp(0, 0, "R5 same cycle last");
    // R5 address with first of two beats
    aw_valid = 1; aw_ready = 1; aw_len = 1;
    w_valid = 1; w_ready = 1; w_strb = 8'hFF; w_last = 0;
    tick();
    aw_valid = 0; w_valid = 0;
    chk_quiet("R5 same cycle first");
    wb(8'hFF, 1, 0, 0, 0, "R5 same cycle first");
    bresp(0, 0, "R5 same cycle first");

    // R8 overflow of address queue (depth 4)
    for (int i = 0; i < 5; i++) begin
      aw(0, 0, 0, 1, 0, "R8 fill");
      chk("R8 ovf", ovf, i == 4);
    end
    for (int i = 0; i < 4; i++) wb(8'h01, 1, 0, 0, 0, "R8 drain");
    for (int i = 0; i < 4; i++) bresp(0, 0, "R8 drain");
    bresp(1, 1, "R7 dropped address gives no response");

    // R9 increment lanes, byte size from lane 3
    aw(3, 2, 0, 1, 0, "R9");
    wb(8'h08, 0, 0, 0, 0, "R9 beat0");
    wb(8'h20, 0, 0, 0, 1, "R9 beat1 wrong lane");
    wb(8'h20, 1, 0, 0, 0, "R9 beat2");
    bresp(0, 0, "R9");
    // R9 unaligned word start
    aw(1, 0, 2, 1, 0, "R9 unaligned");
    wb(8'h0F, 1, 0, 0, 1, "R9 unaligned lane0");
    bresp(0, 0, "R9 unaligned");

    // R10 fixed lanes
    aw(2, 1, 1, 0, 0, "R10");
    wb(8'h0C, 0, 0, 0, 0, "R10 beat0");
    wb(8'h03, 1, 0, 0, 1, "R10 beat1 moved");
    bresp(0, 0, "R10");

    // R11 wrap lanes 6,7,4,5
    aw(6, 3, 0, 2, 0, "R11");
    wb(8'h40, 0, 0, 0, 0, "R11 b0");
    wb(8'h80, 0, 0, 0, 0, "R11 b1");
    wb(8'h10, 0, 0, 0, 0, "R11 b2 wrapped");
    wb(8'h01, 1, 0, 0, 1, "R11 b3 unwrapped lane");
    bresp(0, 0, "R11");

    // R13 stall then payload change
    w_valid = 1; w_ready = 0; w_data = 64'h1111; w_strb = 8'hFF;
    tick();
    chk("R13 first stall", wstable_err, 1'b0);
    tick();
    chk("R13 held payload", wstable_err, 1'b0);
    w_data = 64'h2222;
    tick();
    chk("R13 changed payload", wstable_err, 1'b1);
    w_valid = 0;
    tick();
    chk("R13 after drop", wstable_err, 1'b0);

    // R9/R10 random bursts
    for (int n = 0; n < 40; n++) begin
      int a, l, s, bt;
      a = int'($urandom % 4096);
      l = int'($urandom % 6);
      s = int'($urandom % 4);
      bt = int'($urandom % 2);
      aw(a, l, s, bt, 0, "R9 rnd");
      for (int k = 0; k <= l; k++) begin
        logic [7:0] m, st;
        logic bad;
        m = exp_mask(a, l, s, bt, k);
        st = 8'($urandom) & m;
        bad = (($urandom % 5) == 0) && (m != 8'hFF);
        if (bad) begin
          for (int j = NB - 1; j >= 0; j--) if (!m[j]) st = 8'(1) << j;
          st = st | m;
        end
        wb(st, k == l, 0, 0, bad, bt == 0 ? "R10 rnd" : "R9 rnd");
      end
      bresp(0, 0, "R5 rnd");
    end

    tick();
    chk_quiet("R1 idle end");
    summary();
    $finish;
  end
endmodule